// File: doc/BRIEF.md
# Packet Receiver Control Register Slice

This block is the control and status register slice of a packet receiver. A simple word-wide register bus reaches a control register with three bits: core enable, soft reset and full reset. From these bits the block drives the receiver's hold-side outputs:

- a flush line for each of the three internal FIFOs (lane input, packet, generic short packet),
- a one-cycle abort pulse for the packet-processing state machine,
- a lane shutdown line,
- a reset line for the PHY-side controller.

Incoming packets arrive as single data words marked with start and end flags. They are forwarded, one cycle later, to an AXI4-Stream style output (TVALID, TDATA, TLAST, TUSER). When the core is disabled or held in reset while a packet is part-way through, the slice closes that packet with one synthetic beat that carries an error flag in TUSER bit 1. It then discards the rest of that packet.

Other registers hold:

- the active-lane setting,
- a global interrupt enable, an interrupt enable mask and a write-one-to-clear interrupt status,
- a saturating count of aborted packets,
- a live view of three FIFO-full flags that come from another clock domain.

A soft or full reset clears the status and count. It leaves the control, lane and interrupt-enable settings alone.

Top module: `rxc_ctrl_top`

## Requirements
- R1: After the asynchronous reset, the control register reads 0x1 (enabled), the lane field reads DEF_LANES, and the global enable, enable mask, status and abort count read 0. Lane shutdown, all flushes, PHY reset, irq and TVALID are low.
- R2: Control register at offset 0x00: bit 0 is enable, bit 1 is soft reset, bit 2 is full reset. Bits 31..3 read as 0, and a read of any unmapped offset returns 0.
- R3: lane_shutdown is high exactly when enable is 0 and soft reset is 0. Soft reset suppresses shutdown even when the core is disabled.
- R4: All three fifo_flush bits are high whenever the core is held (enable 0, soft reset 1 or full reset 1). core_abort is high for exactly the first cycle of each held interval.
- R5: phy_reset follows the full-reset bit.
- R6: While not held, a packet whose first word carries start forwards every word with one cycle of latency. TUSER[0]=1 on the first beat only, TLAST=1 on the word carrying end, and TUSER[1]=0 throughout.
- R7: If the core becomes held while a packet is open, the next output is exactly one beat with TVALID=1, TLAST=1, TUSER=2'b10 and TDATA=0. No further beat of that packet follows.
- R8: Input words are dropped while the core is held. When the core is not held and no packet is open, words without start are dropped.
- R9: While soft or full reset is 1, the interrupt status (0x24) and abort count (0x14) are forced to 0. Control (0x00), lane field (0x04 bits [LANE_W-1:0]), global enable (0x20 bit 0) and enable mask (0x28 bits [1:0]) keep their values.
- R10: Interrupt status at 0x24: bit 0 is set by an abort and bit 1 by a rising edge of any synchronized FIFO-full flag. Writing 1 to a bit clears it. irq = global enable AND any(status AND mask).
- R11: The abort count at 0x14 increments by one for each aborted packet and saturates at 2^CNT_W-1.
- R12: The status register at 0x10 bits [2:0] (lane FIFO, packet FIFO, short-packet FIFO full) pass through a two-flop synchronizer. A read sampled at the second clock edge after an input change returns the old value, and a read sampled at the third edge returns the new one.
- R13: Read data is registered: it reflects the register addressed at the clock edge where the read enable was high, and holds otherwise. Status bit 8 is 1 while a packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and datapath |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| in_valid | input | 1 | Input word valid |
| in_data | input | DATA_W | Input word |
| in_sop | input | 1 | Input word starts a packet |
| in_eop | input | 1 | Input word ends a packet |
| m_tvalid | output | 1 | Output beat valid |
| m_tdata | output | DATA_W | Output beat data |
| m_tlast | output | 1 | Last beat of a packet |
| m_tuser | output | 2 | Bit 0 start of packet, bit 1 packet error |
| fifo_full_async | input | 3 | FIFO-full flags from the core clock domain |
| fifo_flush | output | 3 | Flush for lane, packet and short-packet FIFOs |
| core_abort | output | 1 | One-cycle abort to the packet state machine |
| lane_shutdown | output | 1 | Lane shutdown request |
| phy_reset | output | 1 | Reset to the PHY-side controller |
| active_lanes | output | LANE_W | Active-lane setting |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DATA_W=8, CNT_W=3, LANE_W=2 and DEF_LANES=3. The 3-bit abort count makes saturation reachable after seven aborts, and the bench drives nine so that the wrap point is crossed. All eight control-register values are swept in sequence, so every transition into and out of the held state checks shutdown, flush, abort pulse and PHY reset. All eight FIFO-full patterns are swept, each read at both the second and the third edge after the change.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int NUM_FIFO = 3;
    localparam int NUM_IRQ  = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LANES = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ACNT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_GIE   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_ISR   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_IER   = 8'h28;

    localparam int STAT_ACTIVE_BIT = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PKT  = 1'b1
    } pkt_st_e;

    typedef struct packed {
        logic full_rst;
        logic soft_rst;
        logic enable;
    } ctrl_t;
endpackage

// File: rtl/rxc_sync.sv
module rxc_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_in;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level = sync_q.s2;

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] = sync_q.s2[g] & ~sync_q.s3[g];
    end

    // R12: the output level moves only to what the first stage held one cycle before
    p_sync_two_stage_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level == $past(sync_q.s1)));
endmodule

// File: rtl/rxc_pkt_gate.sv
module rxc_pkt_gate
    import rxc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              m_tvalid,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic [1:0]        m_tuser,
    output logic              abort_evt,
    output logic              hold_edge,
    output logic              pkt_active
);
    typedef struct packed {
        pkt_st_e           st;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              last;
        logic [1:0]        user;
        logic              hold_prev;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d           = gate_q;
        gate_d.valid     = 1'b0;
        gate_d.data      = '0;
        gate_d.last      = 1'b0;
        gate_d.user      = 2'b00;
        gate_d.hold_prev = hold;
        abort_evt        = 1'b0;
        if (hold) begin
            if (gate_q.st == ST_PKT) begin
                abort_evt    = 1'b1;
                gate_d.valid = 1'b1;
                gate_d.last  = 1'b1;
                gate_d.user  = 2'b10;
            end
            gate_d.st = ST_IDLE;
        end else if (in_valid) begin
            if (gate_q.st == ST_IDLE) begin
                if (in_sop) begin
                    gate_d.valid = 1'b1;
                    gate_d.data  = in_data;
                    gate_d.user  = 2'b01;
                    gate_d.last  = in_eop;
                    gate_d.st    = in_eop ? ST_IDLE : ST_PKT;
                end
            end else begin
                gate_d.valid = 1'b1;
                gate_d.data  = in_data;
                gate_d.last  = in_eop;
                if (in_eop) begin
                    gate_d.st = ST_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '{st: ST_IDLE, valid: 1'b0, data: '0, last: 1'b0,
                        user: 2'b00, hold_prev: 1'b0};
        end else begin
            gate_q <= gate_d;
        end
    end

    assign m_tvalid   = gate_q.valid;
    assign m_tdata    = gate_q.data;
    assign m_tlast    = gate_q.last;
    assign m_tuser    = gate_q.user;
    assign hold_edge  = hold & ~gate_q.hold_prev;
    assign pkt_active = (gate_q.st == ST_PKT);

    // R7: an abort produces one closing beat flagged with the error bit
    p_abort_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> (m_tvalid && m_tlast && m_tuser == 2'b10));

    // R8: with the core held and nothing open, no beat leaves
    p_hold_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !pkt_active) |=> !m_tvalid);

    // R7: after a closing error beat no packet is left open
    p_closed_after_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> !pkt_active);
endmodule

// File: rtl/rxc_regs.sv
module rxc_regs
    import rxc_pkg::*;
#(
    parameter int LANE_W    = 2,
    parameter int CNT_W     = 8,
    parameter int DEF_LANES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic                abort_evt,
    input  logic [NUM_FIFO-1:0] full_lvl,
    input  logic [NUM_FIFO-1:0] full_rise,
    input  logic                pkt_active,
    output logic [REG_W-1:0]    rdata,
    output ctrl_t               ctrl,
    output logic [LANE_W-1:0]   lanes,
    output logic                irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [LANE_W-1:0] LANES_RST = LANE_W'(DEF_LANES);

    typedef struct packed {
        ctrl_t               ctrl;
        logic [LANE_W-1:0]   lanes;
        logic                gie;
        logic [NUM_IRQ-1:0]  ier;
        logic [NUM_IRQ-1:0]  isr;
        logic [CNT_W-1:0]    acnt;
        logic [REG_W-1:0]    rdata;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  clr;
    logic [REG_W-1:0] rd_val;

    assign clr = regs_q.ctrl.soft_rst | regs_q.ctrl.full_rst;

    always_comb begin
        rd_val = '0;
        case (addr)
            OFS_CTRL:  rd_val[2:0]          = regs_q.ctrl;
            OFS_LANES: rd_val[LANE_W-1:0]   = regs_q.lanes;
            OFS_STAT: begin
                rd_val[NUM_FIFO-1:0]    = full_lvl;
                rd_val[STAT_ACTIVE_BIT] = pkt_active;
            end
            OFS_ACNT:  rd_val[CNT_W-1:0]    = regs_q.acnt;
            OFS_GIE:   rd_val[0]            = regs_q.gie;
            OFS_ISR:   rd_val[NUM_IRQ-1:0]  = regs_q.isr;
            OFS_IER:   rd_val[NUM_IRQ-1:0]  = regs_q.ier;
            default:   rd_val               = '0;
        endcase
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                OFS_CTRL:  regs_d.ctrl  = ctrl_t'(wdata[2:0]);
                OFS_LANES: regs_d.lanes = wdata[LANE_W-1:0];
                OFS_GIE:   regs_d.gie   = wdata[0];
                OFS_IER:   regs_d.ier   = wdata[NUM_IRQ-1:0];
                OFS_ISR:   regs_d.isr   = regs_q.isr & ~wdata[NUM_IRQ-1:0];
                default:   ;
            endcase
        end
        if (abort_evt) begin
            regs_d.isr[0] = 1'b1;
            if (regs_q.acnt != CNT_MAX) begin
                regs_d.acnt = regs_q.acnt + 1'b1;
            end
        end
        if (|full_rise) begin
            regs_d.isr[1] = 1'b1;
        end
        if (clr) begin
            regs_d.isr  = '0;
            regs_d.acnt = '0;
        end
        if (rd_en) begin
            regs_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{ctrl: '{full_rst: 1'b0, soft_rst: 1'b0, enable: 1'b1},
                        lanes: LANES_RST, gie: 1'b0, ier: '0, isr: '0,
                        acnt: '0, rdata: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = regs_q.rdata;
    assign ctrl  = regs_q.ctrl;
    assign lanes = regs_q.lanes;
    assign irq   = regs_q.gie & |(regs_q.isr & regs_q.ier);

    // R9: a soft or full reset leaves status and count empty on the next cycle
    p_clear_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (regs_q.isr == '0 && regs_q.acnt == '0));

    // R11: a saturated count stays put until cleared
    p_cnt_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.acnt == CNT_MAX && !clr) |=> (regs_q.acnt == CNT_MAX));

    // R9: settings kept by reset rules change only through a bus write
    p_keep_settings_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(regs_q.ctrl) && $stable(regs_q.lanes)
                    && $stable(regs_q.gie) && $stable(regs_q.ier)));

    // R13: read data holds when no read is issued
    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/rxc_ctrl_top.sv
module rxc_ctrl_top
    import rxc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LANE_W    = 2,
    parameter int CNT_W     = 8,
    parameter int DEF_LANES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              m_tvalid,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic [1:0]        m_tuser,
    input  logic [2:0]        fifo_full_async,
    output logic [2:0]        fifo_flush,
    output logic              core_abort,
    output logic              lane_shutdown,
    output logic              phy_reset,
    output logic [LANE_W-1:0] active_lanes,
    output logic              irq
);
    ctrl_t               ctrl;
    logic                hold;
    logic                abort_evt;
    logic                pkt_active;
    logic [NUM_FIFO-1:0] full_lvl;
    logic [NUM_FIFO-1:0] full_rise;

    rxc_sync #(
        .N(NUM_FIFO)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (fifo_full_async),
        .level    (full_lvl),
        .rise     (full_rise)
    );

    rxc_regs #(
        .LANE_W    (LANE_W),
        .CNT_W     (CNT_W),
        .DEF_LANES (DEF_LANES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .rd_en      (reg_rd),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .abort_evt  (abort_evt),
        .full_lvl   (full_lvl),
        .full_rise  (full_rise),
        .pkt_active (pkt_active),
        .rdata      (reg_rdata),
        .ctrl       (ctrl),
        .lanes      (active_lanes),
        .irq        (irq)
    );

    assign hold = ~ctrl.enable | ctrl.soft_rst | ctrl.full_rst;

    rxc_pkt_gate #(
        .DATA_W(DATA_W)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .m_tvalid   (m_tvalid),
        .m_tdata    (m_tdata),
        .m_tlast    (m_tlast),
        .m_tuser    (m_tuser),
        .abort_evt  (abort_evt),
        .hold_edge  (core_abort),
        .pkt_active (pkt_active)
    );

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_flush
        assign fifo_flush[g] = hold;
    end

    assign lane_shutdown = ~ctrl.enable & ~ctrl.soft_rst;
    assign phy_reset     = ctrl.full_rst;

    // R4: the abort request lasts a single cycle
    p_abort_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_abort |=> !core_abort);

    // R3: shutdown never coincides with a soft reset
    p_no_shutdown_in_srst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_shutdown |-> !fifo_flush[0] || !ctrl.soft_rst);

    // R4: all flush lines move together
    p_flush_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_flush == 3'b000) || (fifo_flush == 3'b111));
endmodule

// File: tb/tb_rxc_ctrl_top.sv
module tb_rxc_ctrl_top;
    localparam int DW = 8;
    localparam int LW = 2;
    localparam int CW = 3;
    localparam int DL = 3;
    localparam int CMAX = (1 << CW) - 1;

    localparam logic [7:0] A_CTRL = 8'h00, A_LANES = 8'h04, A_STAT = 8'h10,
                           A_ACNT = 8'h14, A_GIE = 8'h20, A_ISR = 8'h24,
                           A_IER = 8'h28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          m_tvalid, m_tlast;
    logic [DW-1:0] m_tdata;
    logic [1:0]    m_tuser;
    logic [2:0]    fifo_full_async = '0;
    logic [2:0]    fifo_flush;
    logic          core_abort, lane_shutdown, phy_reset, irq;
    logic [LW-1:0] active_lanes;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    rxc_ctrl_top #(.DATA_W(DW), .LANE_W(LW), .CNT_W(CW), .DEF_LANES(DL)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tuser(m_tuser),
        .fifo_full_async(fifo_full_async), .fifo_flush(fifo_flush),
        .core_abort(core_abort), .lane_shutdown(lane_shutdown),
        .phy_reset(phy_reset), .active_lanes(active_lanes), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic beat(input logic [DW-1:0] d, input logic s, input logic e);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        @(negedge clk);
    endtask

    task automatic quiet();
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic chk_beat(input string req, input logic [DW-1:0] d,
                            input logic last, input logic [1:0] user);
        chk({req, " tvalid"}, 32'(m_tvalid), 32'd1);
        chk({req, " tdata"},  32'(m_tdata),  32'(d));
        chk({req, " tlast"},  32'(m_tlast),  32'(last));
        chk({req, " tuser"},  32'(m_tuser),  32'(user));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [2:0]  prev_ctrl;
        logic [2:0]  prev_full;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 lane_shutdown", 32'(lane_shutdown), 0);
        chk("R1 fifo_flush", 32'(fifo_flush), 0);
        chk("R1 phy_reset", 32'(phy_reset), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tvalid", 32'(m_tvalid), 0);
        chk("R1 active_lanes", 32'(active_lanes), DL);
        rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h1);
        rd(A_LANES, v); chk("R1 lanes", v, DL);
        rd(A_GIE, v);   chk("R1 gie", v, 0);
        rd(A_IER, v);   chk("R1 ier", v, 0);
        rd(A_ISR, v);   chk("R1 isr", v, 0);
        rd(A_ACNT, v);  chk("R1 acnt", v, 0);

        // R2 bit map, reserved bits, unmapped offsets
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v);  chk("R2 reserved bits zero", v, 32'h7);
        rd(8'h30, v);   chk("R2 unmapped offset", v, 0);
        wr(A_CTRL, 32'h1);
        @(negedge clk);

        // R3 R4 R5: sweep every control value in sequence
        prev_ctrl = 3'b001;
        for (int c = 0; c < 8; c++) begin
            logic hold_new, hold_old;
            hold_new = !c[0] || c[1] || c[2];
            hold_old = !prev_ctrl[0] || prev_ctrl[1] || prev_ctrl[2];
            wr(A_CTRL, 32'(c));
            chk("R3 lane_shutdown", 32'(lane_shutdown), 32'(!c[0] && !c[1]));
            chk("R4 fifo_flush", 32'(fifo_flush), hold_new ? 32'h7 : 32'h0);
            chk("R4 core_abort first cycle", 32'(core_abort), 32'(hold_new && !hold_old));
            chk("R5 phy_reset", 32'(phy_reset), 32'(c[2]));
            @(negedge clk);
            chk("R4 core_abort single cycle", 32'(core_abort), 0);
            prev_ctrl = 3'(c);
        end
        wr(A_CTRL, 32'h1);
        @(negedge clk);

        // R6 forwarding, lengths 1 to 4
        for (int len = 1; len <= 4; len++) begin
            for (int b = 0; b < len; b++) begin
                logic [DW-1:0] d;
                d = DW'(len * 16 + b);
                beat(d, b == 0, b == len - 1);
                chk_beat("R6 forward", d, b == len - 1, {1'b0, b == 0});
            end
            quiet();
            @(negedge clk);
            chk("R6 idle after packet", 32'(m_tvalid), 0);
        end

        // R8 word without start while idle is dropped
        beat(8'h55, 1'b0, 1'b0);
        chk("R8 no-start word dropped", 32'(m_tvalid), 0);
        quiet();

        // R7 abort on disable
        beat(8'hA0, 1'b1, 1'b0); chk_beat("R7 pre-abort first", 8'hA0, 0, 2'b01);
        beat(8'hA1, 1'b0, 1'b0); chk_beat("R7 pre-abort second", 8'hA1, 0, 2'b00);
        quiet();
        wr(A_CTRL, 32'h0);
        chk("R7 nothing before abort beat", 32'(m_tvalid), 0);
        beat(8'hA2, 1'b0, 1'b0);
        chk_beat("R7 abort beat", 8'h00, 1, 2'b10);
        beat(8'hA3, 1'b0, 1'b1);
        chk("R8 held word dropped", 32'(m_tvalid), 0);
        beat(8'hB0, 1'b1, 1'b1);
        chk("R8 held start dropped", 32'(m_tvalid), 0);
        quiet();
        rd(A_ISR, v);  chk("R10 abort sets isr bit0", v, 32'h1);
        rd(A_ACNT, v); chk("R11 first abort count", v, 1);
        chk("R10 irq masked by gie", 32'(irq), 0);
        wr(A_CTRL, 32'h1);
        beat(8'hA4, 1'b0, 1'b1);
        chk("R8 tail after release dropped", 32'(m_tvalid), 0);
        beat(8'hC0, 1'b1, 1'b1);
        chk_beat("R6 packet after release", 8'hC0, 1, 2'b01);
        quiet();

        // R10 irq gating and clear-by-one
        wr(A_GIE, 32'h1);
        wr(A_IER, 32'h1);
        chk("R10 irq raised", 32'(irq), 1);
        wr(A_IER, 32'h2);
        chk("R10 irq masked", 32'(irq), 0);
        wr(A_ISR, 32'h1);
        rd(A_ISR, v); chk("R10 write-one clears", v, 0);

        // R9 soft reset clears status and count, keeps settings
        wr(A_LANES, 32'h1);
        wr(A_IER, 32'h3);
        beat(8'hD0, 1'b1, 1'b0);
        quiet();
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        wr(A_CTRL, 32'h1);
        rd(A_ACNT, v); chk("R11 second abort count", v, 2);
        chk("R10 irq with abort pending", 32'(irq), 1);
        beat(8'hD1, 1'b1, 1'b0);
        quiet();
        wr(A_CTRL, 32'h3);
        chk("R3 no shutdown in soft reset", 32'(lane_shutdown), 0);
        @(negedge clk);
        chk_beat("R7 abort beat on soft reset", 8'h00, 1, 2'b10);
        rd(A_ISR, v);   chk("R9 isr cleared", v, 0);
        rd(A_ACNT, v);  chk("R9 count cleared", v, 0);
        rd(A_CTRL, v);  chk("R9 ctrl kept", v, 32'h3);
        rd(A_LANES, v); chk("R9 lanes kept", v, 1);
        chk("R9 lanes port kept", 32'(active_lanes), 1);
        rd(A_GIE, v);   chk("R9 gie kept", v, 1);
        rd(A_IER, v);   chk("R9 ier kept", v, 3);
        wr(A_CTRL, 32'h1);
        rd(A_ISR, v);   chk("R9 isr still empty after release", v, 0);

        // R11 saturation of abort count
        for (int i = 1; i <= 9; i++) begin
            wr(A_CTRL, 32'h1);
            beat(DW'(i), 1'b1, 1'b0);
            quiet();
            wr(A_CTRL, 32'h0);
            @(negedge clk);
            rd(A_ACNT, v);
            chk("R11 abort count", v, (i < CMAX) ? i : CMAX);
        end
        wr(A_CTRL, 32'h1);

        // R12 synchronizer latency sweep
        prev_full = 3'b000;
        for (int p = 0; p < 8; p++) begin
            fifo_full_async = 3'(p);
            @(negedge clk);
            rd(A_STAT, v); chk("R12 old value at second edge", v & 32'h7, 32'(prev_full));
            rd(A_STAT, v); chk("R12 new value at third edge", v & 32'h7, 32'(p));
            prev_full = 3'(p);
        end
        fifo_full_async = 3'b000;
        repeat (3) @(negedge clk);
        rd(A_ISR, v); chk("R10 isr bits after sweep", v, 32'h3);
        wr(A_ISR, 32'h3);
        rd(A_ISR, v); chk("R10 both bits cleared", v, 0);

        // R13 packet-active status bit and registered read data
        beat(8'hE0, 1'b1, 1'b0);
        quiet();
        rd(A_STAT, v); chk("R13 active bit set", 32'(v[8]), 1);
        beat(8'hE1, 1'b0, 1'b1);
        quiet();
        rd(A_STAT, v); chk("R13 active bit clear", 32'(v[8]), 0);
        rd(A_LANES, v);
        reg_addr = A_IER;
        @(negedge clk);
        chk("R13 read data holds without strobe", reg_rdata, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule